// File: doc/BRIEF.md
# Scrolling LED Matrix Controller

This block drives one 8x8 LED matrix so that a long run of glyph bytes slides across it. A read-only table, set by a constant parameter, holds the display stream with one byte per matrix line. Consecutive groups of eight bytes form glyphs, and the stream opens with eight zero bytes so that each pass starts from a dark screen. A fast scan counter steps through the eight lines, and a slower offset counter moves the starting point through the stream.

The byte shown on line `m` is read from address `(offset + m) mod STREAM_LEN`. The offset advances by one only at the end of a complete 8-line frame, after a programmed number of frames. The line select is active low and the pixel data is active high. The select is registered in the same stage as the table read, so both buses change on the same edge. The scan and scroll rates come from two plain divider inputs. No data crosses the block's edge as a stream, so it has no valid/ready handshake and no back-pressure.

Top module: `led_scroll_ctrl`

## Requirements
- R1: Each clock edge that samples `rst` high sets `row_sel_n` to 8'hFF (all lines dark) and `pix` to 8'h00.
- R2: After reset is released, exactly one bit of `row_sel_n` is low on every cycle.
- R3: The driven line index advances by one every `scan_div`+1 cycles and goes 0,1,...,7,0. Line `k` is driven by `row_sel_n` = ~(1<<k).
- R4: `pix` holds table byte `(offset + k) mod STREAM_LEN` for the line `k` shown on `row_sel_n` in the same cycle. Table byte `i` sits at bits `[8i+7:8i]` of `TABLE`.
- R5: The offset starts at 0 after reset. It advances by one only when line 7 completes, and only on every (`frame_div`+1)-th such frame end.
- R6: The offset wraps from `STREAM_LEN`-1 to 0. Every line address also wraps modulo `STREAM_LEN`.
- R7: With `scan_div` = 0 the line changes on every cycle, and with `frame_div` = 0 the offset steps on every frame.
- R8: Both outputs are registered. The first cycle after reset is released shows line 0 at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_div | input | DIV_W | Cycles per line minus one |
| frame_div | input | FRM_W | Frames per scroll step minus one |
| row_sel_n | output | 8 | Line select, active low, one-hot |
| pix | output | 8 | Pixel data for the selected line, active high |

## Verification
The bench builds the block with a 24-byte stream. The first eight bytes are zero and the other sixteen are computed nonzero values, so any wrong address shows up as a wrong pixel byte. Because the stream is this short, each divider setting runs through every offset, every line and the offset wrap within a few thousand cycles. The bench repeats this for several divider pairs, including both zero settings, and compares every cycle against a line and offset position worked out arithmetically from the cycle count.

// File: rtl/led_scroll_pkg.sv
package led_scroll_pkg;
  localparam int LINES = 8;
  localparam int PIX_W = 8;
  localparam int LIDX_W = $clog2(LINES);
  typedef logic [LIDX_W-1:0] line_idx_t;
  typedef logic [PIX_W-1:0]  pix_t;

  // 24-byte default stream: eight blanks, then two glyphs
  localparam int DEF_LEN = 24;
  localparam logic [8*DEF_LEN-1:0] DEF_TABLE = {
    64'h00_18_18_7E_7E_18_18_00,
    64'h00_66_66_7E_7E_66_66_00,
    64'h00_00_00_00_00_00_00_00
  };
endpackage

// File: rtl/scan_timer.sv
module scan_timer
  import led_scroll_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] scan_div,
  output line_idx_t        line_idx,
  output logic             frame_end
);
  logic [DIV_W-1:0] pre_q;
  line_idx_t        line_q;
  logic             line_tick;

  assign line_tick = (pre_q >= scan_div);
  assign frame_end = line_tick && (line_q == line_idx_t'(LINES - 1));
  assign line_idx  = line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      line_q <= '0;
    end else if (line_tick) begin
      pre_q  <= '0;
      line_q <= line_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !line_tick |=> $stable(line_q)); // R3
endmodule

// File: rtl/scroll_offset.sv
module scroll_offset #(
  parameter int STREAM_LEN = 24,
  parameter int FRM_W      = 8,
  localparam int AW        = $clog2(STREAM_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FRM_W-1:0] frame_div,
  input  logic             frame_end,
  output logic [AW-1:0]    offset
);
  localparam logic [AW-1:0] LAST = AW'(STREAM_LEN - 1);
  logic [FRM_W-1:0] fcnt_q;
  logic [AW-1:0]    off_q;

  assign offset = off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q <= '0;
      off_q  <= '0;
    end else if (frame_end) begin
      if (fcnt_q >= frame_div) begin
        fcnt_q <= '0;
        off_q  <= (off_q == LAST) ? '0 : off_q + 1'b1;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(off_q)); // R5
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (rst)
    off_q <= LAST); // R6
endmodule

// File: rtl/glyph_rom.sv
module glyph_rom #(
  parameter int STREAM_LEN = 24,
  parameter logic [8*STREAM_LEN-1:0] TABLE = '0,
  localparam int AW = $clog2(STREAM_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] offset,
  input  logic [2:0]    line,
  output logic [7:0]    data
);
  localparam logic [AW:0] LEN_W = (AW+1)'(STREAM_LEN);
  logic [AW:0]   sum;
  logic [AW-1:0] addr;

  assign sum  = {1'b0, offset} + (AW+1)'(line);
  assign addr = (sum >= LEN_W) ? AW'(sum - LEN_W) : AW'(sum);

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= TABLE[{addr, 3'b000} +: 8];
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    addr < AW'(STREAM_LEN)); // R6
endmodule

// File: rtl/led_scroll_ctrl.sv
module led_scroll_ctrl
  import led_scroll_pkg::*;
#(
  parameter int STREAM_LEN = DEF_LEN,
  parameter logic [8*STREAM_LEN-1:0] TABLE = DEF_TABLE,
  parameter int DIV_W = 16,
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] scan_div,
  input  logic [FRM_W-1:0] frame_div,
  output logic [7:0]       row_sel_n,
  output logic [7:0]       pix
);
  localparam int AW = $clog2(STREAM_LEN);

  line_idx_t     line_idx;
  logic          frame_end;
  logic [AW-1:0] offset;

  scan_timer #(.DIV_W(DIV_W)) u_scan (
    .clk(clk), .rst(rst), .scan_div(scan_div),
    .line_idx(line_idx), .frame_end(frame_end)
  );

  scroll_offset #(.STREAM_LEN(STREAM_LEN), .FRM_W(FRM_W)) u_scroll (
    .clk(clk), .rst(rst), .frame_div(frame_div),
    .frame_end(frame_end), .offset(offset)
  );

  glyph_rom #(.STREAM_LEN(STREAM_LEN), .TABLE(TABLE)) u_rom (
    .clk(clk), .rst(rst), .offset(offset), .line(line_idx), .data(pix)
  );

  // select registered in the same stage as the table read
  always_ff @(posedge clk) begin
    if (rst) row_sel_n <= 8'hFF;
    else     row_sel_n <= ~(8'h01 << line_idx);
  end

  AST_RESET_DARK: assert property (@(posedge clk)
    rst |=> (row_sel_n == 8'hFF && pix == 8'h00)); // R1
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ($countones(~row_sel_n) == 1)); // R2
endmodule

// File: tb/led_scroll_ctrl_tb.sv
module led_scroll_ctrl_tb;
  localparam int N = 24;

  function automatic logic [8*N-1:0] make_table();
    logic [8*N-1:0] t;
    t = '0;
    for (int i = 8; i < N; i++) t[8*i +: 8] = 8'((i * 29 + 7) % 256) | 8'h01;
    return t;
  endfunction

  localparam logic [8*N-1:0] TBL = make_table();

  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] scan_div = '0;
  logic [7:0]  frame_div = '0;
  logic [7:0]  row_sel_n, pix;

  int checks = 0, fails = 0;
  bit done = 0;

  led_scroll_ctrl #(.STREAM_LEN(N), .TABLE(TBL), .DIV_W(16), .FRM_W(8)) u_dut (
    .clk(clk), .rst(rst), .scan_div(scan_div), .frame_div(frame_div),
    .row_sel_n(row_sel_n), .pix(pix)
  );

  always #2 clk = ~clk;

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cfg(int sd, int fd);
    int s, total;
    @(negedge clk);
    rst = 1; scan_div = 16'(sd); frame_div = 8'(fd);
    repeat (3) @(negedge clk);
    check8("R1 sel in reset", row_sel_n, 8'hFF);
    check8("R1 pix in reset", pix, 8'h00);
    rst = 0;
    s = sd + 1;
    total = N * 8 * (fd + 1) * s + 8 * s * (fd + 1) * 2;
    for (int k = 1; k <= total; k++) begin
      int t, ln, m, fr, n, a;
      @(posedge clk); #1;
      t  = k - 1;
      ln = t / s;
      m  = ln % 8;
      fr = ln / 8;
      n  = (fr / (fd + 1)) % N;
      a  = (n + m) % N;
      if (k == 1) begin
        check8("R8 first sel", row_sel_n, 8'hFE);
        check8("R8 first pix", pix, 8'h00);
      end
      checks++;
      if ($countones(~row_sel_n) != 1) begin
        fails++;
        $display("FAIL R2 one-hot: actual %h expected one low bit", row_sel_n);
      end
      check8(sd == 0 ? "R3/R7 line" : "R3 line", row_sel_n, ~(8'h01 << m));
      check8(fd == 0 ? "R4/R5/R6/R7 pix" : "R4/R5/R6 pix", pix, TBL[8*a +: 8]);
    end
  endtask

  initial begin
    run_cfg(0, 0);
    run_cfg(1, 1);
    run_cfg(2, 0);
    run_cfg(0, 3);
    // reset mid-run returns to dark state (R1)
    @(negedge clk); rst = 1;
    @(negedge clk);
    check8("R1 sel after mid reset", row_sel_n, 8'hFF);
    check8("R1 pix after mid reset", pix, 8'h00);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule